// File: doc/BRIEF.md
# Cyclic Vector Unpack Engine

The engine takes a command that describes a packed element format and a vector count, pulls the packed data from a stream of 32-bit operand words, and writes one 128-bit four-lane vector per step into a vector memory. An element format has one to four lanes of 32-, 16- or 8-bit fields, or a fixed 5-5-5-1 layout. Each field can be sign-extended to 32 bits. Fields are read at continuous bit offsets, so a vector may span two operand words.

Two cycle values shape where vectors land and where filler vectors appear. With CL below WL, every group of WL vectors holds CL data vectors followed by zero filler vectors. The filler vectors consume no operand data. With CL at or above WL, each group of WL data vectors is followed by a gap of CL−WL unwritten slots. A remaining-vector count is visible while the command runs.

The command, the operand stream and the memory write port all use valid/ready handshakes. The engine accepts a command only when it is idle. It takes an operand word only when the current or a later data vector needs more bits. It holds a write offer steady for as long as the memory back-pressures. The cycle values and the offset register value are plain inputs, and they are sampled when the command is accepted.

Top module: `vec_unpack_engine`

## Requirements
- R1: `cmd_fmt[3:2]` holds the lane count minus one. Width code `cmd_fmt[1:0]` values 0, 1 and 2 give unit widths U of 32, 16 and 8 bits. The vector width is V = U × lanes. Lane i of data vector r is the U-bit field at operand bit r·V + i·U. Operand bits are numbered LSB-first across words, so word j holds bits 32j to 32j+31. The field goes to `mem_wdata[32i+31:32i]`, zero-extended, and lanes at or above the lane count are written as zero.
- R2: `cmd_fmt` = 4'b1111 selects the 5-5-5-1 layout. Lanes 0 to 2 are 5-bit fields at vector bits 0, 5 and 10. Lane 3 is the 1-bit field at vector bit 15, and each vector takes 16 operand bits.
- R3: Width code 3 with `cmd_fmt[3:2]` other than 3 is illegal. `err` pulses for one cycle in the cycle after acceptance. No write is made, no operand word is taken, `busy` stays low and `done` does not pulse.
- R4: With `cmd_sext` = 1, each lane field is sign-extended from its own top bit to 32 bits. This includes the 1-bit lane.
- R5: The first destination slot is `cmd_dest` plus (`cmd_add_ofs` ? `ofs_base` : 0), taken modulo 2^ADDR_W. `mem_addr` counts 16-byte slots.
- R6: When CL < WL, vector n goes to slot base+n. If n mod WL ≥ CL, the vector is a filler: all four lanes are zero and it consumes no operand bits. Data vectors take the operand bits one after another.
- R7: When CL ≥ WL, vector n goes to slot base + (n div WL)·CL + (n mod WL). A WL of zero is treated as one.
- R8: `rem_cnt` loads `cmd_num` on acceptance and drops by one on each accepted write. `done` pulses for one cycle in the cycle after the final write, with `rem_cnt` at 0. A `cmd_num` of 0 makes `done` pulse in the cycle after acceptance, with no write.
- R9: `busy` is high from the cycle after acceptance until the `done` cycle, in which it is low. `cmd_ready` equals not `busy`.
- R10: A command consumes exactly ceil(D·V/32) operand words, where D is its number of data vectors. The unused bits of its last word are dropped.
- R11: While `mem_wvalid` is high and `mem_wready` is low, `mem_wvalid`, `mem_addr` and `mem_wdata` hold steady. An operand word moves only in a cycle with both `op_valid` and `op_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_fmt | input | 4 | Lane count and width code |
| cmd_sext | input | 1 | Sign-extend fields |
| cmd_add_ofs | input | 1 | Add offset register to base |
| cmd_dest | input | DEST_W | Base slot |
| cmd_num | input | NUM_W | Vectors to write |
| cyc_cl | input | CYC_W | CL cycle value |
| cyc_wl | input | CYC_W | WL cycle value |
| ofs_base | input | OFS_W | Base-offset register value |
| op_valid | input | 1 | Operand word offered |
| op_ready | output | 1 | Operand word taken |
| op_data | input | 32 | Operand word |
| mem_wvalid | output | 1 | Vector write offered |
| mem_wready | input | 1 | Memory accepts write |
| mem_addr | output | ADDR_W | Destination slot |
| mem_wdata | output | 128 | Vector, lane 0 in low bits |
| busy | output | 1 | Transfer in progress |
| rem_cnt | output | NUM_W | Vectors still to write |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Illegal format pulse |

## Verification
A filler write and the intake of an operand word for a later data vector can happen in the same cycle. This is the only point where the operand and memory sides of the engine overlap. The case is provoked with CL=1, WL=3 and a four-lane 32-bit format, with the operand stream always valid and the memory ready toggling. The result is judged at the ports: every slot must receive its exact vector or zeros, and the number of operand words consumed must equal the count derived from the data vectors alone. Taking one word too many or one too few shows up as a count error or as corrupted data in the next data vector.

// File: rtl/vup_pkg.sv
package vup_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;
  localparam int BUF_W  = VEC_W + WORD_W;
  localparam int CNT_W  = $clog2(BUF_W + 1);

  typedef struct packed {
    logic [2:0] lanes;      // 1..4
    logic [5:0] unit_w;     // 5, 8, 16, 32
    logic [7:0] vec_w;      // bits consumed per data vector
    logic       thin_last;  // last lane is one bit wide
  } fmt_t;
endpackage

// File: rtl/vup_fmt_decode.sv
module vup_fmt_decode
  import vup_pkg::*;
(
  input  logic [3:0] code,
  output fmt_t       fmt,
  output logic       bad
);
  always_comb begin
    fmt.lanes     = {1'b0, code[3:2]} + 3'd1;
    fmt.thin_last = (code[1:0] == 2'd3);
    if (code[1:0] == 2'd3) fmt.unit_w = 6'd5;
    else                   fmt.unit_w = 6'(7'd32 >> code[1:0]);
    if (fmt.thin_last) fmt.vec_w = 8'd16;
    else               fmt.vec_w = 8'(fmt.unit_w) * 8'(fmt.lanes);
    bad = fmt.thin_last && (code[3:2] != 2'd3);
  end
endmodule

// File: rtl/vup_bit_buffer.sv
module vup_bit_buffer #(
  parameter int BUF_W = 160,
  parameter int IN_W  = 32,
  parameter int OUT_W = 128,
  parameter int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [IN_W-1:0]  push_word,
  input  logic             pop,
  input  logic [CNT_W-1:0] pop_len,
  output logic [CNT_W-1:0] count,
  output logic [OUT_W-1:0] window
);
  logic [BUF_W-1:0] store_q, store_d, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;

  always_comb begin
    shifted = pop ? (store_q >> pop_len) : store_q;
    cnt_mid = pop ? (cnt_q - pop_len) : cnt_q;
    store_d = shifted;
    cnt_d   = cnt_mid;
    if (push) begin
      store_d = shifted | (BUF_W'(push_word) << cnt_mid);
      cnt_d   = cnt_mid + CNT_W'(IN_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      store_q <= '0;
      cnt_q   <= '0;
    end else begin
      store_q <= store_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count  = cnt_q;
  assign window = store_q[OUT_W-1:0];
endmodule

// File: rtl/vup_lane_extract.sv
module vup_lane_extract
  import vup_pkg::*;
(
  input  logic [VEC_W-1:0] window,
  input  fmt_t             fmt,
  input  logic             sext,
  output logic [VEC_W-1:0] vec
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IS_LAST = (g == LANES - 1);
    logic [6:0]        off;
    logic [5:0]        w;
    logic [WORD_W-1:0] raw, keep, val;

    always_comb begin
      off  = 7'(g) * 7'(fmt.unit_w);
      w    = (IS_LAST && fmt.thin_last) ? 6'd1 : fmt.unit_w;
      raw  = WORD_W'(window >> off);
      keep = (w >= 6'd32) ? '1 : ((32'd1 << w) - 32'd1);
      val  = raw & keep;
      if (sext && raw[5'(w - 6'd1)]) val = val | ~keep;
    end

    assign vec[g*WORD_W +: WORD_W] = (3'(g) < fmt.lanes) ? val : '0;
  end
endmodule

// File: rtl/vec_unpack_engine.sv
module vec_unpack_engine
  import vup_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_W  = 8,
  parameter int CYC_W  = 8,
  parameter int DEST_W = 10,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_fmt,
  input  logic              cmd_sext,
  input  logic              cmd_add_ofs,
  input  logic [DEST_W-1:0] cmd_dest,
  input  logic [NUM_W-1:0]  cmd_num,
  input  logic [CYC_W-1:0]  cyc_cl,
  input  logic [CYC_W-1:0]  cyc_wl,
  input  logic [OFS_W-1:0]  ofs_base,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [WORD_W-1:0] op_data,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [VEC_W-1:0]  mem_wdata,
  output logic              busy,
  output logic [NUM_W-1:0]  rem_cnt,
  output logic              done,
  output logic              err
);
  localparam int CMP_W = ((NUM_W > CYC_W) ? NUM_W : CYC_W) + 1;

  fmt_t              in_fmt, fmt_q;
  logic              in_bad;
  logic              busy_q, sext_q, done_q, err_q;
  logic [CYC_W-1:0]  cl_q, wl_q, k_q, k_nxt, wl_in;
  logic [NUM_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q, base_in, addr_nxt;
  logic [CNT_W-1:0]  buf_cnt, vec_len;
  logic [VEC_W-1:0]  win, lane_vec;
  logic accept, filler, real_ahead, have_vec, wr_fire, push, pop, last_wr, buf_clr;

  vup_fmt_decode u_dec (.code(cmd_fmt), .fmt(in_fmt), .bad(in_bad));

  vup_bit_buffer #(.BUF_W(BUF_W), .IN_W(WORD_W), .OUT_W(VEC_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(push), .push_word(op_data),
    .pop(pop), .pop_len(vec_len), .count(buf_cnt), .window(win)
  );

  vup_lane_extract u_ext (.window(win), .fmt(fmt_q), .sext(sext_q), .vec(lane_vec));

  always_comb begin
    accept     = cmd_valid && !busy_q;
    wl_in      = (cyc_wl == '0) ? CYC_W'(1) : cyc_wl;
    base_in    = ADDR_W'(cmd_dest) + (cmd_add_ofs ? ADDR_W'(ofs_base) : '0);
    vec_len    = CNT_W'(fmt_q.vec_w);
    filler     = (cl_q < wl_q) && (k_q >= cl_q);
    real_ahead = (cl_q != '0) && (CMP_W'(rem_q) > CMP_W'(wl_q - k_q));
    have_vec   = buf_cnt >= vec_len;
    mem_wvalid = busy_q && (filler || have_vec);
    wr_fire    = mem_wvalid && mem_wready;
    op_ready   = busy_q && (buf_cnt < vec_len) && (!filler || real_ahead);
    push       = op_valid && op_ready;
    pop        = wr_fire && !filler;
    last_wr    = wr_fire && (rem_q == NUM_W'(1));
    buf_clr    = accept || last_wr;
    k_nxt      = (k_q == wl_q - CYC_W'(1)) ? '0 : k_q + CYC_W'(1);
    if ((cl_q >= wl_q) && (k_q == wl_q - CYC_W'(1)))
      addr_nxt = addr_q + ADDR_W'(cl_q - wl_q) + ADDR_W'(1);
    else
      addr_nxt = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sext_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fmt_q  <= '0;
      cl_q   <= '0;
      wl_q   <= CYC_W'(1);
      k_q    <= '0;
      rem_q  <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (in_bad) begin
          err_q <= 1'b1;
        end else if (cmd_num == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          fmt_q  <= in_fmt;
          sext_q <= cmd_sext;
          cl_q   <= cyc_cl;
          wl_q   <= wl_in;
          k_q    <= '0;
          rem_q  <= cmd_num;
          addr_q <= base_in;
        end
      end else if (wr_fire) begin
        rem_q  <= rem_q - NUM_W'(1);
        addr_q <= addr_nxt;
        k_q    <= k_nxt;
        if (last_wr) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = filler ? '0 : lane_vec;
  assign busy      = busy_q;
  assign rem_cnt   = rem_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/vup_checker.sv
module vup_checker #(
  parameter int ADDR_W = 12,
  parameter int NUM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cmd_ready,
  input logic              op_ready,
  input logic              mem_wvalid,
  input logic              mem_wready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [127:0]      mem_wdata,
  input logic [NUM_W-1:0]  rem_cnt
);
  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_addr) && $stable(mem_wdata));
  // R8
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && mem_wready |=> rem_cnt == $past(rem_cnt) - 1'b1);
  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem_cnt == '0);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && cmd_ready);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_wvalid && !op_ready);
  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !done);
endmodule

bind vec_unpack_engine vup_checker #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .cmd_ready(cmd_ready), .op_ready(op_ready), .mem_wvalid(mem_wvalid),
  .mem_wready(mem_wready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .rem_cnt(rem_cnt)
);

// File: tb/vec_unpack_engine_tb.sv
module vec_unpack_engine_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_ready;
  logic [3:0]   cmd_fmt = '0;
  logic         cmd_sext = 1'b0, cmd_add_ofs = 1'b0;
  logic [9:0]   cmd_dest = '0;
  logic [7:0]   cmd_num = '0;
  logic [7:0]   cyc_cl = '0, cyc_wl = '0;
  logic [9:0]   ofs_base = '0;
  logic         op_valid, op_ready;
  logic [31:0]  op_data;
  logic         mem_wvalid;
  logic         mem_wready = 1'b1;
  logic [11:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         busy, done, err;
  logic [7:0]   rem_cnt;

  vec_unpack_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_fmt(cmd_fmt), .cmd_sext(cmd_sext), .cmd_add_ofs(cmd_add_ofs),
    .cmd_dest(cmd_dest), .cmd_num(cmd_num), .cyc_cl(cyc_cl), .cyc_wl(cyc_wl),
    .ofs_base(ofs_base), .op_valid(op_valid), .op_ready(op_ready), .op_data(op_data),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .rem_cnt(rem_cnt), .done(done), .err(err)
  );

  int n_chk = 0, n_bad = 0;
  bit ended = 1'b0;

  logic [31:0]  opw [64];
  int           op_idx = 0;
  logic         clr = 1'b0, bp = 1'b0, hold = 1'b0;
  logic [11:0]  wr_a [64];
  logic [127:0] wr_d [64];
  int           wr_n = 0;
  logic         done_seen = 1'b0, err_seen = 1'b0;
  logic [11:0]  exp_a [64];
  logic [127:0] exp_d [64];
  int           exp_words;
  int           cyc = 0;

  assign op_valid = !clr && (op_idx < 64);
  assign op_data  = opw[op_idx[5:0]];

  always @(posedge clk) begin
    if (clr) begin
      op_idx <= 0; wr_n <= 0; done_seen <= 1'b0; err_seen <= 1'b0;
    end else begin
      if (op_valid && op_ready) op_idx <= op_idx + 1;
      if (mem_wvalid && mem_wready && wr_n < 64) begin
        wr_a[wr_n] <= mem_addr; wr_d[wr_n] <= mem_wdata; wr_n <= wr_n + 1;
      end
      if (done) done_seen <= 1'b1;
      if (err)  err_seen  <= 1'b1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_wready <= hold ? 1'b0 : (bp ? cyc[0] : 1'b1);
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] field(input int pos, input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < w; b++) v[b] = opw[(pos + b) / 32][(pos + b) % 32];
    return v;
  endfunction

  task automatic build_expect(input logic [3:0] f, input bit sx, input logic [11:0] base,
                              input int num, input int cl, input int wl);
    int lanes = f[3:2] + 1;
    bit five = (f[1:0] == 2'd3);
    int uw = five ? 5 : (32 >> f[1:0]);
    int vw = five ? 16 : uw * lanes;
    int wle = (wl == 0) ? 1 : wl;
    int nreal = 0;
    for (int n = 0; n < num; n++) begin
      bit fill = (cl < wle) && ((n % wle) >= cl);
      int r = (cl < wle) ? ((n / wle) * cl + (n % wle)) : n;
      exp_a[n] = (cl < wle) ? 12'(base + n) : 12'(base + (n / wle) * cl + (n % wle));
      exp_d[n] = '0;
      if (!fill) begin
        nreal++;
        for (int i = 0; i < lanes; i++) begin
          int w = (five && i == 3) ? 1 : uw;
          logic [31:0] v = field(r * vw + i * uw, w);
          if (sx && v[w-1]) for (int b = w; b < 32; b++) v[b] = 1'b1;
          exp_d[n][32*i +: 32] = v;
        end
      end
    end
    exp_words = (nreal * vw + 31) / 32;
  endtask

  task automatic run_cmd(input logic [3:0] f, input bit sx, input bit ao, input logic [9:0] dest,
                         input int num, input int cl, input int wl, input logic [9:0] ofs,
                         input bit bpx, input int hold_n, input int seed, input string req);
    bit bad = (f[1:0] == 2'd3) && (f[3:2] != 2'd3);
    logic [11:0] base = 12'(dest) + (ao ? 12'(ofs) : 12'd0);
    int t = 0;
    @(negedge clk);
    clr = 1'b1; bp = bpx; hold = (hold_n > 0);
    for (int j = 0; j < 64; j++) begin
      logic [31:0] h = 32'(j + seed + 1) * 32'h9E3779B9;
      opw[j] = h ^ {h[15:0], h[31:16]};
    end
    build_expect(f, sx, base, num, cl, wl);
    @(negedge clk);
    clr = 1'b0;
    cmd_fmt = f; cmd_sext = sx; cmd_add_ofs = ao; cmd_dest = dest; cmd_num = 8'(num);
    cyc_cl = 8'(cl); cyc_wl = 8'(wl); ofs_base = ofs; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!bad && num > 0) check(busy == 1'b1, {req, " R9 busy after accept"}, 128'(busy), 128'd1);
    if (hold_n > 0) begin
      repeat (hold_n) @(negedge clk);
      check(mem_wvalid == 1'b1, {req, " R11 offer held"}, 128'(mem_wvalid), 128'd1);
      check(rem_cnt == 8'(num), {req, " R8 count before write"}, 128'(rem_cnt), 128'(num));
      check(mem_addr == exp_a[0], {req, " R11 held addr"}, 128'(mem_addr), 128'(exp_a[0]));
      hold = 1'b0;
    end
    while (!done_seen && !err_seen && t < 600) begin
      @(negedge clk); t++;
    end
    repeat (2) @(negedge clk);
    if (bad) begin
      check(err_seen == 1'b1, {req, " R3 err pulse"}, 128'(err_seen), 128'd1);
      check(done_seen == 1'b0, {req, " R3 no done"}, 128'(done_seen), 128'd0);
      check(wr_n == 0, {req, " R3 no write"}, 128'(wr_n), 128'd0);
      check(op_idx == 0, {req, " R3 no operand"}, 128'(op_idx), 128'd0);
    end else begin
      check(done_seen == 1'b1, {req, " R8 done"}, 128'(done_seen), 128'd1);
      check(err_seen == 1'b0, {req, " R3 no err"}, 128'(err_seen), 128'd0);
      check(wr_n == num, {req, " R8 write count"}, 128'(wr_n), 128'(num));
      check(op_idx == exp_words, {req, " R10 words used"}, 128'(op_idx), 128'(exp_words));
      check(rem_cnt == 8'd0, {req, " R8 count at end"}, 128'(rem_cnt), 128'd0);
      for (int n = 0; n < num && n < wr_n; n++) begin
        check(wr_a[n] == exp_a[n], {req, " addr"}, 128'(wr_a[n]), 128'(exp_a[n]));
        check(wr_d[n] == exp_d[n], {req, " data"}, wr_d[n], exp_d[n]);
      end
    end
    check(busy == 1'b0 && cmd_ready == 1'b1, {req, " R9 idle after"}, 128'(busy), 128'd0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R9 reset busy", 128'(busy), 128'd0);
    check(cmd_ready == 1'b1, "R9 reset ready", 128'(cmd_ready), 128'd1);
    check(mem_wvalid == 1'b0 && op_ready == 1'b0, "R11 reset quiet", 128'(mem_wvalid), 128'd0);
    check(done == 1'b0 && err == 1'b0, "R8 reset pulses", 128'({done, err}), 128'd0);
    check(rem_cnt == 8'd0, "R8 reset count", 128'(rem_cnt), 128'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd(4'b1100, 1'b0, 1'b0, 10'h010, 3, 4, 4, 10'h0,   1'b0, 0, 1, "R1 four lanes");
    run_cmd(4'b1010, 1'b0, 1'b0, 10'h020, 5, 1, 1, 10'h0,   1'b1, 0, 2, "R1 R10 three bytes");
    run_cmd(4'b0101, 1'b1, 1'b0, 10'h030, 3, 2, 2, 10'h0,   1'b0, 0, 3, "R4 halves signed");
    run_cmd(4'b1111, 1'b1, 1'b0, 10'h040, 4, 1, 1, 10'h0,   1'b0, 0, 4, "R2 R4 five-five-five-one");
    run_cmd(4'b1111, 1'b0, 1'b0, 10'h048, 3, 1, 1, 10'h0,   1'b1, 0, 9, "R2 unsigned");
    run_cmd(4'b0111, 1'b0, 1'b0, 10'h050, 3, 1, 1, 10'h0,   1'b0, 0, 5, "R3 illegal");
    run_cmd(4'b1100, 1'b0, 1'b0, 10'h060, 6, 1, 3, 10'h0,   1'b1, 0, 6, "R6 filler overlap");
    run_cmd(4'b0000, 1'b0, 1'b1, 10'h3FF, 5, 5, 2, 10'h3F0, 1'b0, 0, 7, "R5 R7 skip");
    run_cmd(4'b0100, 1'b0, 1'b0, 10'h080, 3, 3, 0, 10'h0,   1'b0, 0, 8, "R7 zero WL");
    run_cmd(4'b1100, 1'b0, 1'b0, 10'h090, 0, 1, 1, 10'h0,   1'b0, 0, 9, "R8 empty");
    run_cmd(4'b1100, 1'b0, 1'b0, 10'h0A0, 2, 2, 2, 10'h0,   1'b0, 8, 10, "R11 R8 stall");
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule